// File: doc/BRIEF.md
# Load/Store and Stack Transfer Sequencer

This block is the memory side of an 8-bit processor datapath. Given an operation code and a snapshot of the general registers (B, C, D, E, H, L, A, F) and the 16-bit stack pointer, it forms effective addresses, drives a byte-wide memory port, and steps through accesses that take more than one byte. As side effects it reports the register results: the accumulator on loads, HL after auto-stepping stores, the stack pointer during pushes and pops, and each byte a pop fetches. Decoding, arithmetic and branching belong to other blocks.

Addressing covers stores of A through BC or DE, stores through HL that step HL up or down afterwards, a fixed high page (high byte 0xFF) indexed by C or by an immediate byte, full 16-bit absolute addresses taken from two immediate bytes, and push/pop of any register pair. Immediate bytes come from the instruction stream through a fetch request on the same port. Memory is modelled as combinational: read data belongs to the cycle in which the request is shown.

Top module: `stack_mem_seq`

## Requirements
- R1: During and after reset the block is idle: `busy`, `done`, `mem_req`, `stall` and every write-back enable are 0.
- R2: A `start` is taken only while idle and only for a valid operation code: 1 store A at BC, 2 store A at DE, 3 store A at HL then HL+1, 4 store A at HL then HL-1, 5 load A from high page + C, 6 store A to high page + C, 7 load A from high page + immediate, 8 store A to high page + immediate, 9 load A from absolute address, 10 store A to absolute address, 11 push, 12 pop. Other codes leave the block idle. From the next cycle `busy` is 1 until the last cycle of the sequence, which raises `done`.
- R3: Codes 1 and 2 issue one write of A at {B,C} or {D,E}.
- R4: Codes 3 and 4 issue one write of A at {H,L} and, in the same cycle, report HL+1 or HL-1 on `wb_hl`, wrapping modulo 65536.
- R5: Codes 5 and 6 access address {0xFF, C}; a load reports the read byte to register index 6 (A) in the access cycle.
- R6: Codes 7 and 8 spend one fetch cycle for the immediate byte n, then access {0xFF, n}.
- R7: Codes 9 and 10 fetch the low address byte, then the high address byte, then access A at that address.
- R8: Push (code 11) writes the high register at SP-1, then the low register at SP-2, reporting the new SP each time (wrapping), then spends one stall cycle with no request.
- R9: Pop (code 12) reads the low register at SP and reports SP+1, then reads the high register at SP+1 and reports SP+2.
- R10: Register indices are B=0, C=1, D=2, E=3, H=4, L=5, A=6, F=7; `pair` 0=BC, 1=DE, 2=HL, 3=AF selects high index {pair,0} and low index {pair,1}, so F is the low byte of AF.
- R11: A pop into F clears bits 3:0 of the reported byte.
- R12: A `start` that arrives while busy is ignored; the running sequence completes unchanged and no further one begins.
- R13: Each cycle shows at most one kind of activity: write, data read, immediate fetch (`mem_fetch`, address 0), or stall; outputs not in use are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 4 | Operation code |
| pair | input | 2 | Register pair for push/pop |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_h | input | 8 | Register H |
| reg_l | input | 8 | Register L |
| reg_a | input | 8 | Accumulator |
| reg_f | input | 8 | Flag byte |
| reg_sp | input | 16 | Stack pointer |
| rd_data | input | 8 | Read or fetched byte for the current request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_fetch | output | 1 | Request reads the instruction stream |
| mem_addr | output | 16 | Data address |
| mem_wdata | output | 8 | Byte to write |
| stall | output | 1 | Idle bus cycle ending a push |
| wb8_en | output | 1 | Byte register write-back valid |
| wb8_sel | output | 3 | Byte register index |
| wb8_data | output | 8 | Byte register value |
| wb_hl_en | output | 1 | HL write-back valid |
| wb_hl | output | 16 | New HL |
| wb_sp_en | output | 1 | SP write-back valid |
| wb_sp | output | 16 | New SP |

## Verification
A corrupted step register shows in the very next cycle as a wrong mix of request, fetch and stall strobes, or as `done` at the wrong cycle count. A bad pointer snapshot or stepper shows within the same access as a wrong `mem_addr`, and for push and pop as a broken SP sequence on the second byte. Register selection faults appear as a wrong `wb8_sel` or a wrong byte stored on the first push or pop cycle, and a missing flag mask shows as nonzero low bits on the first pop cycle of AF.

// File: rtl/sms_pkg.sv
package sms_pkg;
    localparam int AW     = 16;
    localparam int DW     = 8;
    localparam int RIDX_W = 3;
    localparam int NREG   = 1 << RIDX_W;

    localparam logic [RIDX_W-1:0] IDX_B = 3'd0;
    localparam logic [RIDX_W-1:0] IDX_C = 3'd1;
    localparam logic [RIDX_W-1:0] IDX_D = 3'd2;
    localparam logic [RIDX_W-1:0] IDX_E = 3'd3;
    localparam logic [RIDX_W-1:0] IDX_H = 3'd4;
    localparam logic [RIDX_W-1:0] IDX_L = 3'd5;
    localparam logic [RIDX_W-1:0] IDX_A = 3'd6;
    localparam logic [RIDX_W-1:0] IDX_F = 3'd7;
    localparam logic [1:0]        PAIR_AF = 2'd3;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_ST_BC  = 4'd1,
        OP_ST_DE  = 4'd2,
        OP_ST_HLI = 4'd3,
        OP_ST_HLD = 4'd4,
        OP_LD_HPC = 4'd5,
        OP_ST_HPC = 4'd6,
        OP_LD_HPI = 4'd7,
        OP_ST_HPI = 4'd8,
        OP_LD_ABS = 4'd9,
        OP_ST_ABS = 4'd10,
        OP_PUSH   = 4'd11,
        OP_POP    = 4'd12
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_LO,
        S_FETCH_HI,
        S_MEM,
        S_PUSH_HI,
        S_PUSH_LO,
        S_STALL,
        S_POP_LO,
        S_POP_HI
    } step_e;

    typedef struct packed {
        step_e         step;
        op_e           op;
        logic [1:0]    pair;
        logic [DW-1:0] acc;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [DW-1:0] imm_lo;
        logic [AW-1:0] ptr;
    } seq_t;

    function automatic logic op_is_valid(input logic [3:0] o);
        return (o >= 4'd1) && (o <= 4'd12);
    endfunction

    function automatic logic op_is_store(input op_e o);
        return (o == OP_ST_BC) || (o == OP_ST_DE) || (o == OP_ST_HLI) ||
               (o == OP_ST_HLD) || (o == OP_ST_HPC) || (o == OP_ST_HPI) ||
               (o == OP_ST_ABS);
    endfunction
endpackage

// File: rtl/sms_ptr_step.sv
module sms_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc,
    output logic [W-1:0] dec
);
    localparam logic [W-1:0] ONE = W'(1);

    // modulo 2^W by truncation
    assign inc = val + ONE;
    assign dec = val - ONE;
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
    import sms_pkg::*;
#(
    parameter logic [DW-1:0] HIGH_PAGE = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [3:0]               op_in,
    input  logic [1:0]               pair_in,
    input  logic [NREG-1:0][DW-1:0]  regs,
    input  logic [AW-1:0]            sp_in,
    input  logic [DW-1:0]            rd_data,
    input  logic [AW-1:0]            ptr_inc,
    input  logic [AW-1:0]            ptr_dec,
    output seq_t                     st_q
);
    seq_t st_d;
    op_e  op_new;

    assign op_new = op_e'(op_in);

    always_comb begin
        st_d = st_q;
        unique case (st_q.step)
            S_IDLE: begin
                if (start && op_is_valid(op_in)) begin
                    st_d.op     = op_new;
                    st_d.pair   = pair_in;
                    st_d.acc    = regs[IDX_A];
                    st_d.hi     = regs[{pair_in, 1'b0}];
                    st_d.lo     = regs[{pair_in, 1'b1}];
                    st_d.imm_lo = '0;
                    st_d.ptr    = '0;
                    unique case (op_new)
                        OP_ST_BC: begin
                            st_d.ptr  = {regs[IDX_B], regs[IDX_C]};
                            st_d.step = S_MEM;
                        end
                        OP_ST_DE: begin
                            st_d.ptr  = {regs[IDX_D], regs[IDX_E]};
                            st_d.step = S_MEM;
                        end
                        OP_ST_HLI, OP_ST_HLD: begin
                            st_d.ptr  = {regs[IDX_H], regs[IDX_L]};
                            st_d.step = S_MEM;
                        end
                        OP_LD_HPC, OP_ST_HPC: begin
                            st_d.ptr  = {HIGH_PAGE, regs[IDX_C]};
                            st_d.step = S_MEM;
                        end
                        OP_LD_HPI, OP_ST_HPI, OP_LD_ABS, OP_ST_ABS: begin
                            st_d.step = S_FETCH_LO;
                        end
                        OP_PUSH: begin
                            st_d.ptr  = sp_in;
                            st_d.step = S_PUSH_HI;
                        end
                        OP_POP: begin
                            st_d.ptr  = sp_in;
                            st_d.step = S_POP_LO;
                        end
                        default: st_d.step = S_IDLE;
                    endcase
                end
            end
            S_FETCH_LO: begin
                if (st_q.op == OP_LD_HPI || st_q.op == OP_ST_HPI) begin
                    st_d.ptr  = {HIGH_PAGE, rd_data};
                    st_d.step = S_MEM;
                end else begin
                    st_d.imm_lo = rd_data;
                    st_d.step   = S_FETCH_HI;
                end
            end
            S_FETCH_HI: begin
                st_d.ptr  = {rd_data, st_q.imm_lo};
                st_d.step = S_MEM;
            end
            S_MEM:     st_d.step = S_IDLE;
            S_PUSH_HI: begin
                st_d.ptr  = ptr_dec;
                st_d.step = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                st_d.ptr  = ptr_dec;
                st_d.step = S_STALL;
            end
            S_STALL:   st_d.step = S_IDLE;
            S_POP_LO: begin
                st_d.ptr  = ptr_inc;
                st_d.step = S_POP_HI;
            end
            S_POP_HI:  st_d.step = S_IDLE;
            default:   st_d.step = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R12: once a sequence runs it is not cut short or restarted
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step != S_IDLE) |=> (st_q.op == $past(st_q.op)));

    // R8: push always passes from the low write into the stall cycle
    a_r8_push_to_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == S_PUSH_LO) |=> (st_q.step == S_STALL));
endmodule

// File: rtl/sms_drive.sv
module sms_drive
    import sms_pkg::*;
#(
    parameter logic [DW-1:0] FLAG_KEEP = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_t              st_q,
    input  logic [DW-1:0]     rd_data,
    input  logic [AW-1:0]     ptr_inc,
    input  logic [AW-1:0]     ptr_dec,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_fetch,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              stall,
    output logic              wb8_en,
    output logic [RIDX_W-1:0] wb8_sel,
    output logic [DW-1:0]     wb8_data,
    output logic              wb_hl_en,
    output logic [AW-1:0]     wb_hl,
    output logic              wb_sp_en,
    output logic [AW-1:0]     wb_sp
);
    always_comb begin
        busy      = (st_q.step != S_IDLE);
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_fetch = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        stall     = 1'b0;
        wb8_en    = 1'b0;
        wb8_sel   = '0;
        wb8_data  = '0;
        wb_hl_en  = 1'b0;
        wb_hl     = '0;
        wb_sp_en  = 1'b0;
        wb_sp     = '0;
        unique case (st_q.step)
            S_FETCH_LO, S_FETCH_HI: begin
                mem_req   = 1'b1;
                mem_fetch = 1'b1;
            end
            S_MEM: begin
                mem_req  = 1'b1;
                mem_addr = st_q.ptr;
                done     = 1'b1;
                if (op_is_store(st_q.op)) begin
                    mem_we    = 1'b1;
                    mem_wdata = st_q.acc;
                end else begin
                    wb8_en   = 1'b1;
                    wb8_sel  = IDX_A;
                    wb8_data = rd_data;
                end
                if (st_q.op == OP_ST_HLI) begin
                    wb_hl_en = 1'b1;
                    wb_hl    = ptr_inc;
                end else if (st_q.op == OP_ST_HLD) begin
                    wb_hl_en = 1'b1;
                    wb_hl    = ptr_dec;
                end
            end
            S_PUSH_HI, S_PUSH_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_dec;
                mem_wdata = (st_q.step == S_PUSH_HI) ? st_q.hi : st_q.lo;
                wb_sp_en  = 1'b1;
                wb_sp     = ptr_dec;
            end
            S_STALL: begin
                stall = 1'b1;
                done  = 1'b1;
            end
            S_POP_LO, S_POP_HI: begin
                mem_req  = 1'b1;
                mem_addr = st_q.ptr;
                wb8_en   = 1'b1;
                wb_sp_en = 1'b1;
                wb_sp    = ptr_inc;
                if (st_q.step == S_POP_LO) begin
                    wb8_sel  = {st_q.pair, 1'b1};
                    wb8_data = (st_q.pair == PAIR_AF) ? (rd_data & FLAG_KEEP) : rd_data;
                end else begin
                    wb8_sel  = {st_q.pair, 1'b0};
                    wb8_data = rd_data;
                    done     = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R13: one kind of bus activity per cycle
    a_r13_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req && mem_we, mem_req && !mem_we && !mem_fetch, mem_fetch, stall}));

    a_r13_fetch_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fetch |-> (mem_req && !mem_we && mem_addr == '0));

    // R11: restored flag byte has its low bits cleared
    a_r11_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wb8_en && wb8_sel == IDX_F) |-> ((wb8_data & ~FLAG_KEEP) == '0));

    // R4: HL write-back is a neighbour of the address written
    a_r4_hl_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        wb_hl_en |-> (mem_we && (wb_hl == AW'(mem_addr + 1'b1) || wb_hl == AW'(mem_addr - 1'b1))));

    // R8: stall cycle follows a write
    a_r8_stall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(mem_req && mem_we));

    // R8: consecutive push writes step SP down by one
    a_r8_push_sp_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_sp_en && mem_we && $past(wb_sp_en && mem_we)) |-> (wb_sp == AW'($past(wb_sp) - 1'b1)));

    // R9: consecutive pop reads step SP up by one
    a_r9_pop_sp_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_sp_en && !mem_we && $past(wb_sp_en && !mem_we)) |-> (wb_sp == AW'($past(wb_sp) + 1'b1)));
endmodule

// File: rtl/stack_mem_seq.sv
module stack_mem_seq
    import sms_pkg::*;
#(
    parameter logic [7:0] HIGH_PAGE = 8'hFF,
    parameter logic [7:0] FLAG_KEEP = 8'hF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [3:0]  op,
    input  logic [1:0]  pair,
    input  logic [7:0]  reg_b,
    input  logic [7:0]  reg_c,
    input  logic [7:0]  reg_d,
    input  logic [7:0]  reg_e,
    input  logic [7:0]  reg_h,
    input  logic [7:0]  reg_l,
    input  logic [7:0]  reg_a,
    input  logic [7:0]  reg_f,
    input  logic [15:0] reg_sp,
    input  logic [7:0]  rd_data,
    output logic        busy,
    output logic        done,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_fetch,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        stall,
    output logic        wb8_en,
    output logic [2:0]  wb8_sel,
    output logic [7:0]  wb8_data,
    output logic        wb_hl_en,
    output logic [15:0] wb_hl,
    output logic        wb_sp_en,
    output logic [15:0] wb_sp
);
    logic [NREG-1:0][DW-1:0] regs;
    seq_t                    st_q;
    logic [AW-1:0]           ptr_inc;
    logic [AW-1:0]           ptr_dec;

    assign regs = {reg_f, reg_a, reg_l, reg_h, reg_e, reg_d, reg_c, reg_b};

    sms_ptr_step #(.W(AW)) u_step (
        .val (st_q.ptr),
        .inc (ptr_inc),
        .dec (ptr_dec)
    );

    sms_ctrl #(.HIGH_PAGE(HIGH_PAGE)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_in   (op),
        .pair_in (pair),
        .regs    (regs),
        .sp_in   (reg_sp),
        .rd_data (rd_data),
        .ptr_inc (ptr_inc),
        .ptr_dec (ptr_dec),
        .st_q    (st_q)
    );

    sms_drive #(.FLAG_KEEP(FLAG_KEEP)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_q      (st_q),
        .rd_data   (rd_data),
        .ptr_inc   (ptr_inc),
        .ptr_dec   (ptr_dec),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_fetch (mem_fetch),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .stall     (stall),
        .wb8_en    (wb8_en),
        .wb8_sel   (wb8_sel),
        .wb8_data  (wb8_data),
        .wb_hl_en  (wb_hl_en),
        .wb_hl     (wb_hl),
        .wb_sp_en  (wb_sp_en),
        .wb_sp     (wb_sp)
    );

    // R2: a sequence only begins from a start request
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R1: nothing is requested while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || stall || wb8_en || wb_hl_en || wb_sp_en));
endmodule

// File: tb/stack_mem_seq_test.sv
module stack_mem_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  pair = '0;
    logic [7:0]  r_b = 0, r_c = 0, r_d = 0, r_e = 0, r_h = 0, r_l = 0, r_a = 0, r_f = 0;
    logic [15:0] r_sp = 0;
    logic [7:0]  rd_data;
    logic [7:0]  imm_lo = 0, imm_hi = 0;
    logic        busy, done, mem_req, mem_we, mem_fetch, stall;
    logic [15:0] mem_addr, wb_hl, wb_sp;
    logic [7:0]  mem_wdata, wb8_data;
    logic        wb8_en, wb_hl_en, wb_sp_en;
    logic [2:0]  wb8_sel;
    logic [1:0]  fcnt = '0;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    stack_mem_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pair(pair),
        .reg_b(r_b), .reg_c(r_c), .reg_d(r_d), .reg_e(r_e), .reg_h(r_h),
        .reg_l(r_l), .reg_a(r_a), .reg_f(r_f), .reg_sp(r_sp), .rd_data(rd_data),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_fetch(mem_fetch), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .stall(stall), .wb8_en(wb8_en), .wb8_sel(wb8_sel), .wb8_data(wb8_data),
        .wb_hl_en(wb_hl_en), .wb_hl(wb_hl), .wb_sp_en(wb_sp_en), .wb_sp(wb_sp)
    );

    function automatic logic [7:0] rdf(input logic [15:0] ad);
        return ad[7:0] ^ ad[15:8] ^ 8'h3C;
    endfunction

    always_comb rd_data = mem_fetch ? ((fcnt == 2'd0) ? imm_lo : imm_hi) : rdf(mem_addr);

    always @(posedge clk) fcnt <= !busy ? 2'd0 : fcnt + {1'b0, mem_fetch};

    logic [75:0] act;
    assign act = {mem_req, mem_we, mem_fetch, stall, done, busy, mem_addr, mem_wdata,
                  wb8_en, wb8_sel, wb8_data, wb_hl_en, wb_hl, wb_sp_en, wb_sp};

    function automatic logic [75:0] bx(input logic req, we, fe, st, dn, input logic [15:0] ad,
                                       input logic [7:0] wd, input logic w8e, input logic [2:0] sl,
                                       input logic [7:0] w8d, input logic hle, input logic [15:0] hl,
                                       input logic spe, input logic [15:0] sp);
        return {req, we, fe, st, dn, 1'b1, ad, wd, w8e, sl, w8d, hle, hl, spe, sp};
    endfunction

    function automatic logic [7:0] getr(input logic [2:0] i);
        case (i)
            3'd0: return r_b;  3'd1: return r_c;  3'd2: return r_d;  3'd3: return r_e;
            3'd4: return r_h;  3'd5: return r_l;  3'd6: return r_a;  default: return r_f;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [75:0] a, input logic [75:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, {busy, mem_req, stall, done, wb8_en, wb_hl_en, wb_sp_en, 69'd0}, 76'd0);
    endtask

    // Runs one operation; ign asserts a second start during the first busy cycle
    task automatic run_op(input logic [3:0] o, input logic [1:0] p, input logic ign);
        logic [75:0] ex[3];
        int          n;
        string       tg;
        logic [15:0] hl, sp, ad;
        logic [7:0]  lob;
        hl = {r_h, r_l};
        sp = r_sp;
        n = 1;
        case (o)
            4'd1: begin tg = "R3"; ex[0] = bx(1,1,0,0,1,{r_b,r_c},r_a,0,0,0,0,0,0,0); end
            4'd2: begin tg = "R3"; ex[0] = bx(1,1,0,0,1,{r_d,r_e},r_a,0,0,0,0,0,0,0); end
            4'd3: begin tg = "R4"; ex[0] = bx(1,1,0,0,1,hl,r_a,0,0,0,1,hl+16'd1,0,0); end
            4'd4: begin tg = "R4"; ex[0] = bx(1,1,0,0,1,hl,r_a,0,0,0,1,hl-16'd1,0,0); end
            4'd5: begin tg = "R5"; ad = {8'hFF,r_c}; ex[0] = bx(1,0,0,0,1,ad,0,1,3'd6,rdf(ad),0,0,0,0); end
            4'd6: begin tg = "R5"; ex[0] = bx(1,1,0,0,1,{8'hFF,r_c},r_a,0,0,0,0,0,0,0); end
            4'd7, 4'd8: begin
                tg = "R6/R13"; n = 2; ad = {8'hFF, imm_lo};
                ex[0] = bx(1,0,1,0,0,0,0,0,0,0,0,0,0,0);
                ex[1] = (o == 4'd7) ? bx(1,0,0,0,1,ad,0,1,3'd6,rdf(ad),0,0,0,0)
                                    : bx(1,1,0,0,1,ad,r_a,0,0,0,0,0,0,0);
            end
            4'd9, 4'd10: begin
                tg = "R7/R13"; n = 3; ad = {imm_hi, imm_lo};
                ex[0] = bx(1,0,1,0,0,0,0,0,0,0,0,0,0,0);
                ex[1] = ex[0];
                ex[2] = (o == 4'd9) ? bx(1,0,0,0,1,ad,0,1,3'd6,rdf(ad),0,0,0,0)
                                    : bx(1,1,0,0,1,ad,r_a,0,0,0,0,0,0,0);
            end
            4'd11: begin
                tg = "R8/R10"; n = 3;
                ex[0] = bx(1,1,0,0,0,sp-16'd1,getr({p,1'b0}),0,0,0,0,0,1,sp-16'd1);
                ex[1] = bx(1,1,0,0,0,sp-16'd2,getr({p,1'b1}),0,0,0,0,0,1,sp-16'd2);
                ex[2] = {5'b00011, 1'b1, 70'd0};
            end
            default: begin
                tg = (p == 2'd3) ? "R9/R10/R11" : "R9/R10"; n = 2;
                lob = (p == 2'd3) ? (rdf(sp) & 8'hF0) : rdf(sp);
                ex[0] = bx(1,0,0,0,0,sp,0,1,{p,1'b1},lob,0,0,1,sp+16'd1);
                ex[1] = bx(1,0,0,0,1,sp+16'd1,0,1,{p,1'b0},rdf(sp+16'd1),0,0,1,sp+16'd2);
            end
        endcase
        op = o; pair = p; start = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(tg, act, ex[k]);
            if (k == 0 && ign) begin
                start = 1'b1; op = 4'd12; pair = ~p;   // R12: must be ignored
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk_idle(ign ? "R12" : "R2");
    endtask

    task automatic rand_regs();
        r_b = 8'($urandom); r_c = 8'($urandom); r_d = 8'($urandom); r_e = 8'($urandom);
        r_h = 8'($urandom); r_l = 8'($urandom); r_a = 8'($urandom); r_f = 8'($urandom);
        r_sp = 16'($urandom); imm_lo = 8'($urandom); imm_hi = 8'($urandom);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // R2: undefined codes leave the block idle
        op = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_idle("R2");
        op = 4'd15; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_idle("R2");

        // directed pass over every code
        r_b = 8'h12; r_c = 8'h34; r_d = 8'h56; r_e = 8'h78; r_h = 8'h9A; r_l = 8'hBC;
        r_a = 8'hA5; r_f = 8'hB7; r_sp = 16'hD000; imm_lo = 8'h80; imm_hi = 8'hC1;
        for (int o = 1; o <= 12; o++) run_op(4'(o), 2'(o), 1'b0);

        // R4: HL wrap both ways
        r_h = 8'hFF; r_l = 8'hFF; run_op(4'd3, 2'd0, 1'b0);
        r_h = 8'h00; r_l = 8'h00; run_op(4'd4, 2'd0, 1'b0);
        // R8: SP wrap on push of every pair
        r_sp = 16'h0001;
        for (int p = 0; p < 4; p++) run_op(4'd11, 2'(p), 1'b0);
        // R9, R11: pop wrap and flag masking (rdf gives nonzero low bits here)
        r_sp = 16'hFFFF; run_op(4'd12, 2'd3, 1'b0);
        r_sp = 16'h2001; run_op(4'd12, 2'd3, 1'b0);
        // R12: start while busy
        r_sp = 16'h4000; run_op(4'd11, 2'd1, 1'b1);
        imm_lo = 8'h10; imm_hi = 8'h20; run_op(4'd9, 2'd0, 1'b1);

        // random mix
        for (int i = 0; i < 120; i++) begin
            rand_regs();
            run_op(4'(1 + ($urandom % 12)), 2'($urandom % 4), 1'(($urandom % 5) == 0));
        end
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end
endmodule